// File: doc/BRIEF.md
# Fractional-N Divider Word Calculator

This block turns a requested oscillator frequency and a reference frequency, both unsigned integers in hertz, into the feedback-divider setting of a fractional-N synthesizer. The setting has an 8-bit integer word and an 18-bit fraction. The fraction is delivered as two full bytes and a 2-bit top field, ready for byte-wide configuration storage. From the same request the block also picks a loop proportional-gain code and a clock-inverter code by frequency thresholds, and it presents a fixed lock-detect rate value.

A request is launched with a one-cycle `start` while the block is idle. The quotient comes from a restoring shift-subtract divider that resolves one quotient bit per clock. When the last bit is resolved, every result register is loaded together and `done` pulses for one cycle. A request whose target lies outside the supported band, or whose reference is zero, is refused: it raises an error flag and leaves every earlier result in place.

Top module: `fracn_divcalc`

## Requirements
- R1: After reset, `busy`, `done` and `range_err` are 0, and the integer word, the three fraction fields, `gain_code` and `inv_code` are all 0.
- R2: The divisor is twice `ref_hz` when `prescale_off` is 0, and `ref_hz` itself when `prescale_off` is 1.
- R3: The combined word is floor(`target_hz` × 2^18 / divisor). `int_word` is bits [25:18] of that word, so any higher bits are dropped. The fraction is bits [17:0].
- R4: `frac_lo` carries fraction bits [7:0], `frac_mid` carries bits [15:8], and `frac_hi` carries bits [17:16].
- R5: `gain_code` is 8 for a target at or below 1 900 000 000, 10 for a target at or below 3 000 000 000, and 12 above that.
- R6: `inv_code` is 8 for a target below 1 100 000 000, and 0 otherwise.
- R7: `lockdet_rate` always reads 64.
- R8: A start whose target is below 1 000 000 000 or above 3 500 000 000, or whose `ref_hz` is 0, sets `range_err` and pulses `done` one clock after the start edge. `busy` stays low and every result output keeps its previous value. An accepted in-range start clears `range_err` at its start edge.
- R9: For an in-range request, `busy` is high from the start edge up to the edge that raises `done`. `done` is a one-cycle pulse that comes 51 clock edges after the start edge, and all results change on that same edge.
- R10: A `start` that arrives while `busy` is high is ignored. The running request finishes with its own inputs and at its own time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a request when idle |
| target_hz | input | 32 | Requested oscillator frequency in Hz |
| ref_hz | input | 32 | Reference frequency in Hz |
| prescale_off | input | 1 | 1: divide by the reference itself, 0: by twice the reference |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| range_err | output | 1 | Last request was refused |
| int_word | output | 8 | Integer divider word |
| frac_lo | output | 8 | Fraction bits [7:0] |
| frac_mid | output | 8 | Fraction bits [15:8] |
| frac_hi | output | 2 | Fraction bits [17:16] |
| gain_code | output | 4 | Proportional-gain code |
| inv_code | output | 4 | Clock-inverter code |
| lockdet_rate | output | 8 | Lock-detect rate, fixed |

## Verification
Requests are placed exactly on each threshold and one hertz above it, at both ends of the legal band, and one hertz outside each end. This separates `<` from `<=` in every comparison and in the range check. Several reference values are tried with both prescaler settings, so a divisor that is doubled or not doubled by mistake shows up in the integer and fraction fields. One request has a quotient wider than the integer field, which checks that the upper bits are dropped. A second start issued during a running request checks that the request in flight is left alone. Refused requests with a low target, a high target and a zero reference are placed after valid ones, so that a design that overwrites held results is exposed.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int unsigned FREQ_W = 32;

  localparam logic [FREQ_W-1:0] BAND_MIN     = 32'd1000000000;
  localparam logic [FREQ_W-1:0] BAND_MAX     = 32'd3500000000;
  localparam logic [FREQ_W-1:0] GAIN_LOW_TOP = 32'd1900000000;
  localparam logic [FREQ_W-1:0] GAIN_MID_TOP = 32'd3000000000;
  localparam logic [FREQ_W-1:0] INV_EDGE     = 32'd1100000000;

  localparam logic [7:0] LOCKDET_VALUE = 8'd64;

  function automatic logic [3:0] gain_pick(input logic [FREQ_W-1:0] f);
    if (f <= GAIN_LOW_TOP)      return 4'd8;
    else if (f <= GAIN_MID_TOP) return 4'd10;
    else                        return 4'd12;
  endfunction

  function automatic logic [3:0] inv_pick(input logic [FREQ_W-1:0] f);
    return (f < INV_EDGE) ? 4'd8 : 4'd0;
  endfunction

  function automatic logic request_legal(input logic [FREQ_W-1:0] f,
                                         input logic [FREQ_W-1:0] r);
    return (f >= BAND_MIN) && (f <= BAND_MAX) && (r != '0);
  endfunction
endpackage

// File: rtl/fracn_code_sel.sv
module fracn_code_sel
  import fracn_pkg::*;
(
  input  logic [FREQ_W-1:0] target_hz,
  input  logic [FREQ_W-1:0] ref_hz,
  output logic [3:0]        gain_sel,
  output logic [3:0]        inv_sel,
  output logic              legal
);
  always_comb begin
    gain_sel = gain_pick(target_hz);
    inv_sel  = inv_pick(target_hz);
    legal    = request_legal(target_hz, ref_hz);
  end
endmodule

// File: rtl/fracn_rdiv.sv
module fracn_rdiv #(
  parameter int unsigned DVD_W = 50,
  parameter int unsigned DVS_W = 33,
  parameter int unsigned QW    = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             fin,
  output logic [QW-1:0]    quot
);
  localparam int unsigned CNT_W = $clog2(DVD_W + 1);

  logic [DVS_W-1:0] rem_q;
  logic [DVS_W-1:0] dvs_q;
  logic [DVD_W-1:0] dq_q;
  logic [CNT_W-1:0] cnt_q;

  logic [DVS_W:0] trial;
  logic [DVS_W:0] diff;
  logic           fits;
  logic           last_step;

  always_comb begin
    trial     = {rem_q, dq_q[DVD_W-1]};
    diff      = trial - {1'b0, dvs_q};
    fits      = trial >= {1'b0, dvs_q};
    last_step = busy && (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvs_q <= '0;
      dq_q  <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        rem_q <= '0;
        dq_q  <= dividend;
        dvs_q <= divisor;
        cnt_q <= CNT_W'(DVD_W);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
        dq_q  <= {dq_q[DVD_W-2:0], fits};
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_step) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign quot = dq_q[QW-1:0];

  // R3: partial remainder always stays below the divisor
  p_rem_below_divisor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dvs_q != '0) |-> (rem_q < dvs_q));

  // R9: the loop ends only through the finish pulse
  p_end_with_fin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> fin);
endmodule

// File: rtl/fracn_divcalc.sv
module fracn_divcalc
  import fracn_pkg::*;
#(
  parameter int unsigned FRAC_W = 18,
  parameter int unsigned INT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [FREQ_W-1:0]    target_hz,
  input  logic [FREQ_W-1:0]    ref_hz,
  input  logic                 prescale_off,
  output logic                 busy,
  output logic                 done,
  output logic                 range_err,
  output logic [INT_W-1:0]     int_word,
  output logic [7:0]           frac_lo,
  output logic [7:0]           frac_mid,
  output logic [FRAC_W-17:0]   frac_hi,
  output logic [3:0]           gain_code,
  output logic [3:0]           inv_code,
  output logic [7:0]           lockdet_rate
);
  localparam int unsigned DVD_W = FREQ_W + FRAC_W;
  localparam int unsigned DVS_W = FREQ_W + 1;
  localparam int unsigned CW_W  = INT_W + FRAC_W;

  logic [3:0]       gain_sel, inv_sel;
  logic             legal;
  logic             div_busy, div_fin;
  logic [CW_W-1:0]  quot;
  logic             idle, accept, launch;
  logic [DVD_W-1:0] dividend;
  logic [DVS_W-1:0] divisor;
  logic [3:0]       gain_pend, inv_pend;

  fracn_code_sel u_sel (
    .target_hz (target_hz),
    .ref_hz    (ref_hz),
    .gain_sel  (gain_sel),
    .inv_sel   (inv_sel),
    .legal     (legal)
  );

  always_comb begin
    idle     = !div_busy && !div_fin;
    accept   = start && idle;
    launch   = accept && legal;
    dividend = {target_hz, {FRAC_W{1'b0}}};
    divisor  = prescale_off ? {1'b0, ref_hz} : {ref_hz, 1'b0};
  end

  fracn_rdiv #(.DVD_W(DVD_W), .DVS_W(DVS_W), .QW(CW_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch),
    .dividend (dividend),
    .divisor  (divisor),
    .busy     (div_busy),
    .fin      (div_fin),
    .quot     (quot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      range_err <= 1'b0;
      int_word  <= '0;
      frac_lo   <= '0;
      frac_mid  <= '0;
      frac_hi   <= '0;
      gain_code <= '0;
      inv_code  <= '0;
      gain_pend <= '0;
      inv_pend  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (legal) begin
          range_err <= 1'b0;
          gain_pend <= gain_sel;
          inv_pend  <= inv_sel;
        end else begin
          range_err <= 1'b1;
          done      <= 1'b1;
        end
      end
      if (div_fin) begin
        done      <= 1'b1;
        int_word  <= quot[CW_W-1:FRAC_W];
        frac_lo   <= quot[7:0];
        frac_mid  <= quot[15:8];
        frac_hi   <= quot[FRAC_W-1:16];
        gain_code <= gain_pend;
        inv_code  <= inv_pend;
      end
    end
  end

  assign busy         = div_busy | div_fin;
  assign lockdet_rate = LOCKDET_VALUE;

  // R9: finishing the division raises done and frees the block
  p_fin_gives_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    div_fin |=> (done && !busy));

  // R8: a refused request leaves all results untouched
  p_refused_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && range_err) |-> ($stable(int_word) && $stable(frac_lo) &&
      $stable(frac_mid) && $stable(frac_hi) && $stable(gain_code) &&
      $stable(inv_code)));

  // R5: gain code takes only its three legal values
  p_gain_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !range_err) |-> (gain_code == 4'd8 || gain_code == 4'd10 ||
      gain_code == 4'd12));

  // R6: inverter code takes only its two legal values
  p_inv_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !range_err) |-> (inv_code == 4'd8 || inv_code == 4'd0));

  // R10: while busy, the captured request codes do not move
  p_busy_keeps_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(gain_pend) && $stable(inv_pend)));
endmodule

// File: tb/test_fracn_divcalc.sv
module test_fracn_divcalc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] target_hz = '0;
  logic [31:0] ref_hz = '0;
  logic        prescale_off = 1'b0;
  logic        busy, done, range_err;
  logic [7:0]  int_word, frac_lo, frac_mid;
  logic [1:0]  frac_hi;
  logic [3:0]  gain_code, inv_code;
  logic [7:0]  lockdet_rate;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  localparam int LAT = 51;

  longint m_int = 0, m_lo = 0, m_mid = 0, m_hi = 0, m_gain = 0, m_inv = 0, m_err = 0;

  always #2 clk = ~clk;

  fracn_divcalc i_fracn_divcalc (
    .clk(clk), .rst_n(rst_n), .start(start), .target_hz(target_hz),
    .ref_hz(ref_hz), .prescale_off(prescale_off), .busy(busy), .done(done),
    .range_err(range_err), .int_word(int_word), .frac_lo(frac_lo),
    .frac_mid(frac_mid), .frac_hi(frac_hi), .gain_code(gain_code),
    .inv_code(inv_code), .lockdet_rate(lockdet_rate)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tg);
    check({tg, " R8 range_err"}, range_err, m_err);
    check({tg, " R3 int_word"}, int_word, m_int);
    check({tg, " R4 frac_lo"}, frac_lo, m_lo);
    check({tg, " R4 frac_mid"}, frac_mid, m_mid);
    check({tg, " R4 frac_hi"}, frac_hi, m_hi);
    check({tg, " R5 gain_code"}, gain_code, m_gain);
    check({tg, " R6 inv_code"}, inv_code, m_inv);
    check({tg, " R7 lockdet_rate"}, lockdet_rate, 64);
  endtask

  task automatic run_op(input string tg, input longint t, input longint r,
                        input bit pre, input bit poke);
    longint dv, cw, n_int, n_lo, n_mid, n_hi, n_gain, n_inv;
    bit ok;
    int lat;
    ok = (t >= 64'd1000000000) && (t <= 64'd3500000000) && (r != 0);
    dv = pre ? r : r * 2;
    cw = ok ? (t * 262144) / dv : 0;
    n_int = (cw / 262144) % 256;
    n_lo  = cw % 256;
    n_mid = (cw / 256) % 256;
    n_hi  = (cw / 65536) % 4;
    if (t > 64'd3000000000) n_gain = 12;
    else if (t > 64'd1900000000) n_gain = 10;
    else n_gain = 8;
    n_inv = (t >= 64'd1100000000) ? 0 : 8;
    lat = ok ? LAT : 0;
    @(negedge clk);
    target_hz = t[31:0]; ref_hz = r[31:0]; prescale_off = pre; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j <= lat + 1; j++) begin
      if (j > 0) @(negedge clk);
      if (poke && j == 10) begin
        start = 1'b1; target_hz = 32'd3400000000; prescale_off = ~pre;
      end
      if (poke && j == 11) begin
        start = 1'b0; target_hz = t[31:0]; prescale_off = pre;
      end
      if (j == 0) m_err = ok ? 0 : 1;
      if (ok && j == lat) begin
        m_int = n_int; m_lo = n_lo; m_mid = n_mid; m_hi = n_hi;
        m_gain = n_gain; m_inv = n_inv;
      end
      check({tg, " R9 done"}, done, (j == lat) ? 1 : 0);
      check({tg, " R9 busy"}, busy, (ok && j < lat) ? 1 : 0);
      compare_all(tg);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    compare_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    run_op("R5 R6 band low edge", 64'd1000000000, 64'd19200000, 0, 0);
    run_op("R6 inverter edge", 64'd1100000000, 64'd19200000, 0, 0);
    run_op("R6 below inverter edge", 64'd1099999999, 64'd19200000, 0, 0);
    run_op("R5 gain low top", 64'd1900000000, 64'd19200000, 0, 0);
    run_op("R5 gain above low", 64'd1900000001, 64'd27000000, 0, 0);
    run_op("R5 gain mid top", 64'd3000000000, 64'd19200000, 0, 0);
    run_op("R5 gain above mid", 64'd3000000001, 64'd19200000, 0, 0);
    run_op("R2 prescale off", 64'd2500000000, 64'd38400000, 1, 0);
    run_op("R3 int truncation", 64'd3500000000, 64'd1000000, 1, 0);
    run_op("R8 below band", 64'd999999999, 64'd19200000, 0, 0);
    run_op("R8 above band", 64'd3500000001, 64'd19200000, 0, 0);
    run_op("R8 zero ref", 64'd2000000000, 64'd0, 0, 0);
    run_op("R10 start while busy", 64'd1234567891, 64'd19200000, 0, 1);
    run_op("R2 doubled ref", 64'd1750000123, 64'd24576000, 0, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule